// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block decides, for each of the two source operands of the instruction in the execute stage of a five-stage in-order integer pipeline, where the ALU input mux should take its value from. It can take the value read from the register file, the result held in the execute-to-memory pipeline register, or the result held in the memory-to-writeback register. It compares the execute-stage source register numbers with the destination numbers and write enables of the two older instructions. A dependent ALU instruction that directly follows its producer therefore runs without a stall.

The register file writes in the first half of a cycle and reads in the second half, so an instruction three slots behind its producer already reads the new value and needs no bypass. The block does not bypass from write-back into decode. A load in the memory stage cannot supply its data to the instruction right behind it. In that case the block raises a flag for the stall logic instead of selecting a value that is not there yet. The block is purely combinational, and its outputs drive the operand muxes in the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: Each select output uses the encoding 2'b00 = register-file value, 2'b10 = memory-stage (EX/MEM) result and 2'b01 = write-back-stage (MEM/WB) result. The code 2'b11 never appears.
- R2: An operand selects 2'b10 when the memory-stage instruction writes a register, its destination is nonzero, its destination equals the operand's source register, and it is not a load.
- R3: An operand selects 2'b01 when the write-back-stage instruction writes a nonzero destination equal to the operand's source, and R2 does not apply.
- R4: When both older stages write the same register the operand reads, the memory-stage result wins (2'b10).
- R5: Register 0 is never bypassed. A destination of 0 in either stage leaves the operand at 2'b00 unless the other stage matches.
- R6: A stage whose write enable is low is never a bypass source, even if its destination matches.
- R7: When the memory-stage instruction is a load with a matching nonzero destination and its write enable is high, `load_use` goes high. That operand does not select 2'b10: it takes 2'b01 if write-back matches, otherwise 2'b00.
- R8: The two operands are decided independently of each other. `load_use` is high when either operand meets the condition in R7.
- R9: With no matching producer in either stage, which is the case for a consumer three or more slots behind its producer, the select is 2'b00 and `load_use` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register number of the execute-stage instruction |
| ex_rt | input | 5 | Second source register number of the execute-stage instruction |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination register of the write-back-stage instruction |
| wb_regwrite | input | 1 | Write-back-stage instruction writes a register |
| sel_a | output | 2 | Mux select for operand A (from ex_rs) |
| sel_b | output | 2 | Mux select for operand B (from ex_rt) |
| load_use | output | 1 | A load in the memory stage feeds the execute-stage instruction |

## Verification
The block holds no state, so any fault in a comparator or in the priority logic shows up on the select outputs within the same cycle as the stage contents that expose it. A wrong select feeds the ALU a stale or wrong operand at once. A missing or spurious `load_use` either lets a consumer use load data that is not ready yet or stalls the pipeline for no reason. The stimulus covers an instruction chain that reuses one destination, so each consumer's expected select follows from its distance to the producer. It also covers the register-0, disabled-write, dual-match and load cases on each operand separately.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Operand source select codes
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
// One comparator: does a producing stage write the register a consumer reads?
module fwd_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          we,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = we && (dst != ZERO_REG) && (dst == src);
  end
endmodule

// File: rtl/fwd_operand_sel.sv
// Select logic for one ALU operand.
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_ld,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    sel,
  output logic          ld_hazard
);
  logic mem_hit;
  logic wb_hit;

  fwd_match #(.AW(AW)) u_mem_cmp (
    .src(src), .dst(mem_rd), .we(mem_we), .hit(mem_hit)
  );

  fwd_match #(.AW(AW)) u_wb_cmp (
    .src(src), .dst(wb_rd), .we(wb_we), .hit(wb_hit)
  );

  fwd_src_e choice;

  always_comb begin
    ld_hazard = mem_hit && mem_ld;
    if (mem_hit && !mem_ld) begin
      choice = SRC_MEM;
    end else if (wb_hit) begin
      choice = SRC_WB;
    end else begin
      choice = SRC_RF;
    end
    sel = choice;
  end

  always_comb begin
    a_r1_no_illegal_code: assert (sel != 2'b11)
      else $error("illegal select code");
    a_r7_no_mem_on_load: assert (!(ld_hazard && sel == SRC_MEM))
      else $error("load result bypassed from memory stage");
    a_r4_mem_over_wb: assert (!(mem_hit && !mem_ld && sel == SRC_WB))
      else $error("write-back chosen over memory stage");
    a_r3_wb_taken: assert (!(wb_hit && !mem_hit && sel != SRC_WB))
      else $error("write-back match not selected");
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_regwrite,
  input  logic          mem_memread,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_regwrite,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          load_use
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0][AW-1:0] srcs;
  logic [NUM_SRC-1:0][1:0]    sels;
  logic [NUM_SRC-1:0]         hazards;

  always_comb begin
    srcs    = '0;
    srcs[0] = ex_rs;
    srcs[1] = ex_rt;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
    fwd_operand_sel #(.AW(AW)) u_sel (
      .src       (srcs[i]),
      .mem_rd    (mem_rd),
      .mem_we    (mem_regwrite),
      .mem_ld    (mem_memread),
      .wb_rd     (wb_rd),
      .wb_we     (wb_regwrite),
      .sel       (sels[i]),
      .ld_hazard (hazards[i])
    );
  end

  always_comb begin
    sel_a    = sels[0];
    sel_b    = sels[1];
    load_use = |hazards;
  end

  always_comb begin
    a_r2_mem_needs_writer: assert (!(sel_a == SRC_MEM) ||
        (mem_regwrite && !mem_memread && mem_rd != ZERO_REG && mem_rd == ex_rs))
      else $error("operand A memory bypass without a valid producer");
    a_r6_wb_needs_writer: assert (!(sel_b == SRC_WB) ||
        (wb_regwrite && wb_rd != ZERO_REG && wb_rd == ex_rt))
      else $error("operand B write-back bypass without a valid producer");
    a_r5_zero_never_bypassed: assert (!(ex_rs == ZERO_REG && sel_a != SRC_RF))
      else $error("register 0 bypassed");
    a_r8_flag_needs_load: assert (!load_use || (mem_memread && mem_regwrite))
      else $error("load_use without a load");
  end
endmodule

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] ex_rs = '0, ex_rt = '0, mem_rd = '0, wb_rd = '0;
  logic mem_regwrite = 1'b0, mem_memread = 1'b0, wb_regwrite = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic load_use;

  fwd_unit #(.AW(AW), .NUM_SRC(2)) u0 (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_rd(mem_rd),
    .mem_regwrite(mem_regwrite), .mem_memread(mem_memread),
    .wb_rd(wb_rd), .wb_regwrite(wb_regwrite),
    .sel_a(sel_a), .sel_b(sel_b), .load_use(load_use)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       lu;
    string      req;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference from the requirements
  function automatic logic [1:0] ref_sel(input logic [AW-1:0] s,
      input logic [AW-1:0] mrd, input logic mwe, input logic mld,
      input logic [AW-1:0] wrd, input logic wwe);
    if (mwe && mrd != 0 && mrd == s && !mld) return 2'b10;
    if (wwe && wrd != 0 && wrd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(input logic [AW-1:0] rs, input logic [AW-1:0] rt,
      input logic [AW-1:0] mrd, input logic mwe, input logic mld,
      input logic [AW-1:0] wrd, input logic wwe, input string req);
    item_t it;
    @(negedge clk);
    ex_rs = rs; ex_rt = rt; mem_rd = mrd; mem_regwrite = mwe;
    mem_memread = mld; wb_rd = wrd; wb_regwrite = wwe;
    it.a   = ref_sel(rs, mrd, mwe, mld, wrd, wwe);
    it.b   = ref_sel(rt, mrd, mwe, mld, wrd, wwe);
    it.lu  = mwe && mld && mrd != 0 && (mrd == rs || mrd == rt);
    it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: compares at the rising edge after each drive
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      n_cmp++;
      if (sel_a !== e.a || sel_b !== e.b || load_use !== e.lu) begin
        n_bad++;
        $display("FAIL %s: got a=%b b=%b lu=%b expected a=%b b=%b lu=%b",
                 e.req, sel_a, sel_b, load_use, e.a, e.b, e.lu);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    repeat (2) @(posedge clk);
    // idle pipeline, all zero
    drive(0, 0, 0, 0, 0, 0, 0, "R9 idle");
    // chain: add t0; sub/and/or/xor read t0 (reg 8)
    drive(8, 11, 8, 1, 0, 0, 0, "R2 chain distance 1");
    drive(8, 14, 12, 1, 0, 8, 1, "R3 chain distance 2");
    drive(8, 16, 13, 1, 0, 12, 1, "R9 chain distance 3");
    drive(8, 18, 15, 1, 0, 13, 1, "R9 chain distance 4");
    // operand B sources
    drive(3, 9, 9, 1, 0, 3, 1, "R8 B from mem A from wb");
    drive(4, 5, 6, 1, 0, 5, 1, "R3 B from wb");
    // priority
    drive(7, 7, 7, 1, 0, 7, 1, "R4 both stages match");
    drive(2, 20, 20, 1, 0, 20, 1, "R4 operand B priority");
    // register 0
    drive(0, 0, 0, 1, 0, 0, 1, "R5 zero dest both stages");
    drive(0, 10, 0, 1, 0, 10, 1, "R5 zero mem, B from wb");
    // write enable low
    drive(12, 12, 12, 0, 0, 12, 0, "R6 both disabled");
    drive(12, 1, 12, 0, 0, 12, 1, "R6 mem disabled wb used");
    // loads
    drive(21, 2, 21, 1, 1, 0, 0, "R7 load feeds A");
    drive(2, 21, 21, 1, 1, 21, 1, "R7 load feeds B wb fallback");
    drive(22, 22, 22, 0, 1, 0, 0, "R7 load not writing");
    drive(0, 3, 0, 1, 1, 0, 0, "R7 load to zero reg");
    drive(5, 6, 9, 1, 1, 5, 1, "R8 load no match, A wb");
    drive(1, 2, 3, 1, 0, 4, 1, "R1 unrelated registers");
    repeat (3) @(posedge clk);
    #1;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1 scoreboard: got %0d pending expected 0", sb.size());
    end
    summary();
  end
endmodule